// File: doc/BRIEF.md
# Two-Sector Wait-State Generator

This block sits between a processor's external bus request and a shared memory bus. It stretches each access by a wait count chosen for that access alone. The 16-bit external space is split into a lower and an upper sector at a boundary that software can move. Each sector has its own wait setting, so slow peripherals and fast memory can share one bus. Accesses to the fast sector are never slowed by the slow one.

An access begins when the request strobe is high at a clock edge while the block is idle. The sector and its wait count are captured at that edge. The block then holds its bus-cycle-active output high for one base cycle plus the captured number of wait cycles. It raises a one-cycle ready pulse in the last of those cycles and is idle again on the following cycle.

Top module: `wait_sector_gen`

## Requirements
- R1: After reset, and until a request is accepted, `busy_o` and `ready_o` are both 0.
- R2: When `limit_i` is 0 there is no split, and every address uses `wait_lo_i`.
- R3: When `limit_i` is 1 to 7, an address strictly below `limit_i` × 0x2000 uses `wait_lo_i`.
- R4: When `limit_i` is 1 to 7, an address equal to or above `limit_i` × 0x2000 uses `wait_hi_i`.
- R5: An access with wait setting W (0 to 3) holds `busy_o` high for exactly W+1 cycles. `ready_o` is high only in the last of those cycles.
- R6: A wait setting of 0 completes in a single cycle, with `busy_o` and `ready_o` both high in the first cycle after acceptance. This holds even when the other sector is set to 3.
- R7: Changes to `addr_i`, `limit_i`, `wait_lo_i` or `wait_hi_i` after acceptance do not change the length of the current access.
- R8: A request that is high while an access is in progress, including its ready cycle, is ignored: it neither restarts nor lengthens the access.
- R9: In the cycle after `ready_o`, `busy_o` is 0. A request still held high is then accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled while idle |
| addr_i | input | 16 | Access address |
| limit_i | input | 3 | Sector boundary code (0 = no split, else code × 0x2000) |
| wait_lo_i | input | 2 | Wait cycles for the lower sector |
| wait_hi_i | input | 2 | Wait cycles for the upper sector |
| busy_o | output | 1 | Bus cycle in progress |
| ready_o | output | 1 | Final cycle of the access |

## Verification
A wrong sector decision or a wrong latched count appears as an access whose busy window is too short or too long. This shows up at the ready pulse, at most four cycles after acceptance. A counter or state that fails to return to idle keeps `busy_o` high in the cycle after ready, or lets a held request stretch the access. Both are visible within one cycle of the ready pulse. Addresses just below and exactly at each boundary expose off-by-one errors in the comparison.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   typedef enum logic [0:0] {
      WSG_IDLE   = 1'b0,
      WSG_ACTIVE = 1'b1
   } wsg_state_e;

   localparam int unsigned WSG_ADDR_W  = 16;
   localparam int unsigned WSG_LIMIT_W = 3;
   localparam int unsigned WSG_WAIT_W  = 2;
endpackage

// File: rtl/wsg_sector_decode.sv
module wsg_sector_decode #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LIMIT_W = 3
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [LIMIT_W-1:0] limit_i,
   output logic               upper_o
);
   // boundary = limit * 2^(ADDR_W-LIMIT_W); aligned, so only the top bits matter
   localparam int unsigned TOP_LSB = ADDR_W - LIMIT_W;

   logic [LIMIT_W-1:0] addr_top;
   logic               split_on;

   assign addr_top = addr_i[ADDR_W-1:TOP_LSB];

   generate
      if (LIMIT_W == 1) begin : g_single
         assign split_on = limit_i[0];
      end else begin : g_multi
         assign split_on = |limit_i;
      end
   endgenerate

   always_comb begin
      upper_o = split_on && (addr_top >= limit_i);
   end
endmodule

// File: rtl/wsg_wait_select.sv
module wsg_wait_select #(
   parameter int unsigned WAIT_W = 2
) (
   input  logic              upper_i,
   input  logic [WAIT_W-1:0] wait_lo_i,
   input  logic [WAIT_W-1:0] wait_hi_i,
   output logic [WAIT_W-1:0] wait_o
);
   always_comb begin
      wait_o = upper_i ? wait_hi_i : wait_lo_i;
   end
endmodule

// File: rtl/wsg_wait_counter.sv
module wsg_wait_counter
   import wsg_pkg::*;
#(
   parameter int unsigned WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WAIT_W-1:0] load_i,
   output logic              busy_o,
   output logic              last_o
);
   wsg_state_e        state_q, state_d;
   logic [WAIT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         WSG_IDLE: begin
            if (start_i) begin
               state_d = WSG_ACTIVE;
               cnt_d   = load_i;
            end
         end
         WSG_ACTIVE: begin
            if (cnt_q == '0) begin
               state_d = WSG_IDLE;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: state_d = WSG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WSG_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy_o = (state_q == WSG_ACTIVE);
   assign last_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/wait_sector_gen.sv
module wait_sector_gen #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LIMIT_W = 3,
   parameter int unsigned WAIT_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [LIMIT_W-1:0] limit_i,
   input  logic [WAIT_W-1:0]  wait_lo_i,
   input  logic [WAIT_W-1:0]  wait_hi_i,
   output logic               busy_o,
   output logic               ready_o
);
   generate
      if (LIMIT_W < 1 || LIMIT_W >= ADDR_W) begin : g_bad_limit
         $error("LIMIT_W must be between 1 and ADDR_W-1");
      end
      if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
         $error("WAIT_W must be between 1 and 8");
      end
   endgenerate

   logic              upper;
   logic [WAIT_W-1:0] wait_sel;
   logic              busy;
   logic              start;

   wsg_sector_decode #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) dec_i (
      .addr_i (addr_i),
      .limit_i(limit_i),
      .upper_o(upper)
   );

   wsg_wait_select #(.WAIT_W(WAIT_W)) sel_i (
      .upper_i  (upper),
      .wait_lo_i(wait_lo_i),
      .wait_hi_i(wait_hi_i),
      .wait_o   (wait_sel)
   );

   // request accepted only when idle; held requests are ignored while busy
   assign start = req_i && !busy;

   wsg_wait_counter #(.WAIT_W(WAIT_W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .load_i (wait_sel),
      .busy_o (busy),
      .last_o (ready_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/wait_sector_gen_chk.sv
module wait_sector_gen_chk #(
   parameter int unsigned WAIT_W = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req_i,
   input logic busy_o,
   input logic ready_o
);
   localparam int unsigned MAX_LEN = (1 << WAIT_W);
   logic [WAIT_W:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len <= '0;
      else if (!busy_o) run_len <= '0;
      else              run_len <= run_len + 1'b1;
   end

   // R1: ready never outside a bus cycle
   a_r1_ready_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> busy_o);

   // R5: ready is a single-cycle pulse
   a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);

   // R5: access length bounded by base cycle plus the largest wait
   a_r5_bounded_length: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_len < MAX_LEN));

   // R8: an access in progress is not cut short or restarted
   a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !ready_o) |=> busy_o);

   // R9: idle in the cycle after ready
   a_r9_idle_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !busy_o);

   // R9: idle request is accepted at the next edge
   a_r9_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> busy_o);
endmodule

bind wait_sector_gen wait_sector_gen_chk #(.WAIT_W(WAIT_W)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_i  (req_i),
   .busy_o (busy_o),
   .ready_o(ready_o)
);

// File: tb/wait_sector_gen_tb_top.sv
`timescale 1ns/1ps
module wait_sector_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] addr = '0;
   logic [2:0]  limit = '0;
   logic [1:0]  wlo = '0;
   logic [1:0]  whi = '0;
   logic        busy, ready;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   bit          done    = 1'b0;

   always #5 clk = ~clk;

   wait_sector_gen dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .limit_i(limit),
      .wait_lo_i(wlo), .wait_hi_i(whi), .busy_o(busy), .ready_o(ready)
   );

   function automatic int exp_wait(input logic [15:0] a, input logic [2:0] l,
                                   input logic [1:0] lo, input logic [1:0] hi);
      if (l != 0 && {13'd0, a[15:13]} >= {13'd0, l}) return int'(hi);
      return int'(lo);
   endfunction

   task automatic check(input bit ok, input string req_tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   // one access; hold keeps the request high throughout (R8), scramble
   // changes the configuration after acceptance (R7)
   task automatic access(input logic [15:0] a, input logic [2:0] l,
                         input logic [1:0] lo, input logic [1:0] hi,
                         input bit hold, input bit scramble, input string tag);
      int e, n;
      e = exp_wait(a, l, lo, hi);
      @(negedge clk);
      addr = a; limit = l; wlo = lo; whi = hi; req = 1'b1;
      @(negedge clk);
      if (!hold) req = 1'b0;
      if (scramble) begin
         addr = ~a; limit = ~l; wlo = ~lo; whi = ~hi;
      end
      n = 1;
      while (!ready && n < 8) begin
         check(busy == 1'b1, tag, int'(busy), 1);
         @(negedge clk);
         n++;
      end
      check(busy && ready, tag, int'(ready), 1);
      check(n == e + 1, tag, n, e + 1);
      @(negedge clk);
      check(!busy && !ready, "R9", int'(busy), 0);
      req = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!busy && !ready, "R1", int'(busy | ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !ready, "R1", int'(busy | ready), 0);

      access(16'hF000, 3'd0, 2'd2, 2'd3, 0, 0, "R2");
      access(16'h0000, 3'd0, 2'd1, 2'd3, 0, 0, "R2");
      access(16'h3FFF, 3'd2, 2'd1, 2'd3, 0, 0, "R3");
      access(16'h4000, 3'd2, 2'd1, 2'd3, 0, 0, "R4");
      access(16'hDFFF, 3'd7, 2'd2, 2'd0, 0, 0, "R3");
      access(16'hE000, 3'd7, 2'd2, 2'd0, 0, 0, "R6");
      access(16'h1FFF, 3'd1, 2'd0, 2'd3, 0, 0, "R6");
      access(16'h2000, 3'd1, 2'd0, 2'd3, 0, 0, "R4");
      access(16'hFFFF, 3'd1, 2'd0, 2'd3, 0, 0, "R5");
      access(16'h9000, 3'd4, 2'd0, 2'd3, 0, 1, "R7");
      access(16'h7000, 3'd4, 2'd3, 2'd0, 0, 1, "R7");
      access(16'h8000, 3'd4, 2'd1, 2'd2, 1, 0, "R8");
      access(16'h0100, 3'd4, 2'd0, 2'd2, 1, 0, "R8");

      for (int i = 0; i < 60; i++) begin
         access(16'($urandom), 3'($urandom), 2'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), "R5");
      end

      // R9: back-to-back with request held; second access starts after one idle cycle
      @(negedge clk);
      addr = 16'h0010; limit = 3'd0; wlo = 2'd0; req = 1'b1;
      @(negedge clk);
      check(busy && ready, "R9", int'(ready), 1);
      @(negedge clk);
      check(!busy, "R9", int'(busy), 0);
      @(negedge clk);
      check(busy && ready, "R9", int'(busy), 1);
      req = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200us;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule